// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the device side of a four-wire serial EEPROM with a 2048-byte internal array. A host selects the device by pulling the active-low select line down, clocks in an 8-bit opcode and a 16-bit address, and then either clocks out data or clocks in one byte to store. All four serial inputs are oversampled by a faster system clock. Each one passes through a two-flop synchroniser, and edges of the serial clock and of the select line are found inside the system clock domain.

Reads stream bytes without a limit. The address steps up after every byte and wraps from the top of the array to zero. A write needs a prior write-enable command. It stores its byte only when the select line is released right after the eighth data bit. It then holds a busy flag for a fixed number of system clocks, and a read opcode arriving in that window is refused. The serial output is meant for a tri-state pad: the block drives the data bit and a separate enable.

Top module: `spi_eeprom_slave`

## Requirements
- R1: While the select line is high, and in every phase other than read data, the output enable is low (high impedance).
- R2: Opcode 03h starts a read. The opcode and a 16-bit address are shifted in MSB first on rising serial clock edges, and the data byte is shifted out MSB first, each bit updating on a falling serial clock edge. The first data bit appears on the falling edge that follows the last address bit.
- R3: After each full byte read, the address advances by one and the next byte follows with no new command.
- R4: Reading past address 7FFh continues at 000h.
- R5: Address bits 15 to 11 are ignored, so address F805h reads location 005h.
- R6: Raising the select line partway through a read byte ends the read, and the output enable drops.
- R7: A read opcode received while busy is high is refused. The output enable stays low for the rest of that transaction.
- R8: Opcode 06h sets the write-enable latch. Opcode 02h with the latch clear changes no memory location.
- R9: A write (02h, 16-bit address, data byte) is stored only when the select line rises right after exactly eight data bits. Fewer or more bits discard it and clear the latch.
- R10: A stored write raises busy for exactly WR_CYCLES system clocks and clears the latch, so a following write without a new 06h has no effect.
- R11: If the write-protect input is low when the select line rises, the write is discarded and the latch is cleared.
- R12: Any opcode other than 03h, 02h or 06h is ignored until deselect, with the output enable held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the serial data pad |
| busy | output | 1 | High during the internal write cycle |

## Verification
The assertions assume that each serial clock half period and each select-line change lasts several system clocks. Under that assumption every serial edge produces exactly one synchronised edge pulse, and data is stable when it is sampled. The stimulus keeps the serial clock at 16 system clocks per period and changes the data line only while the serial clock is low. It also keeps the select line still for half a period around every edge, and keeps it high for several periods between transactions. Write-protect changes only while the device is deselected, and write-enable is never sent while busy is high.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam int unsigned ADDR_BITS = 16;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_WDONE,
    ST_IGNORE
  } ee_state_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned EDGE_W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout,
  output logic [EDGE_W-1:0] rise,
  output logic [EDGE_W-1:0] fall
);
  logic [W-1:0]      meta_q;
  logic [W-1:0]      sync_q;
  logic [EDGE_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL[EDGE_W-1:0];
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q[EDGE_W-1:0];
    end
  end

  assign dout = sync_q;

  for (genvar i = 0; i < EDGE_W; i++) begin : g_edge
    assign rise[i] = sync_q[i] & ~prev_q[i];
    assign fall[i] = ~sync_q[i] & prev_q[i];
  end
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/spi_ee_wrtimer.sv
module spi_ee_wrtimer #(
  parameter int unsigned WR_CYCLES = 5000,
  localparam int unsigned CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = CW'(WR_CYCLES - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          wp_s,
  input  logic          busy,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data,
  output logic          miso,
  output logic          miso_oe
);
  ee_state_t               state_q, state_d;
  logic [3:0]              cnt_q, cnt_d;
  logic [ADDR_BITS-1:0]    sh_q, sh_d;
  logic [AW-1:0]           addr_q, addr_d;
  logic [BYTE_BITS-1:0]    wdata_q, wdata_d;
  logic                    is_wr_q, is_wr_d;
  logic                    wel_q, wel_d;
  logic                    miso_q, miso_d;
  logic                    oe_q, oe_d;
  logic [ADDR_BITS-1:0]    sh_next;
  logic [7:0]              opcode;

  assign sh_next = {sh_q[ADDR_BITS-2:0], mosi_s};
  assign opcode  = sh_next[7:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    is_wr_d = is_wr_q;
    wel_d   = wel_q;
    miso_d  = miso_q;
    oe_d    = oe_q;
    commit  = 1'b0;
    if (cs_rise) begin
      if (is_wr_q) begin
        wel_d = 1'b0;
        if (state_q == ST_WDONE && wp_s) commit = 1'b1;
      end
      state_d = ST_IDLE;
      is_wr_d = 1'b0;
      oe_d    = 1'b0;
    end else if (cs_fall) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      is_wr_d = 1'b0;
      oe_d    = 1'b0;
    end else if (!cs_s) begin
      unique case (state_q)
        ST_CMD: if (sck_rise) begin
          sh_d  = sh_next;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == 4'd7) begin
            cnt_d   = '0;
            state_d = ST_IGNORE;
            if (opcode == OP_WREN) begin
              wel_d = 1'b1;
            end else if (opcode == OP_READ) begin
              if (!busy) state_d = ST_ADDR;
            end else if (opcode == OP_WRITE) begin
              if (wel_q && !busy) begin
                state_d = ST_ADDR;
                is_wr_d = 1'b1;
              end
            end
          end
        end
        ST_ADDR: if (sck_rise) begin
          sh_d  = sh_next;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            cnt_d   = '0;
            addr_d  = sh_next[AW-1:0];
            state_d = is_wr_q ? ST_WDATA : ST_RDATA;
          end
        end
        ST_RDATA: if (sck_fall) begin
          miso_d = mem_rdata[~cnt_q[2:0]];
          oe_d   = 1'b1;
          cnt_d  = {1'b0, cnt_q[2:0] + 3'd1};
          if (cnt_q[2:0] == 3'd7) addr_d = addr_q + 1'b1;
        end
        ST_WDATA: if (sck_rise) begin
          wdata_d = {wdata_q[6:0], mosi_s};
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == 4'd7) state_d = ST_WDONE;
        end
        ST_WDONE: if (sck_rise) state_d = ST_IGNORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
      wel_q   <= 1'b0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      is_wr_q <= is_wr_d;
      wel_q   <= wel_d;
      miso_q  <= miso_d;
      oe_q    <= oe_d;
    end
  end

  assign mem_raddr   = addr_q;
  assign commit_addr = addr_q;
  assign commit_data = wdata_q;
  assign miso        = miso_q;
  assign miso_oe     = oe_q;
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int unsigned DEPTH     = 2048,
  parameter int unsigned WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe,
  output logic busy
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic       rst_meta_q, rst_sync_n;
  logic [3:0] lvl;
  logic [1:0] rise, fall;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;
  logic       mem_we;
  logic [AW-1:0] raddr, waddr;
  logic [7:0] rdata, wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  spi_ee_sync #(.W(4), .EDGE_W(2), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .din({wp_n, mosi, sck, cs_n}),
    .dout(lvl), .rise(rise), .fall(fall)
  );

  assign cs_rise  = rise[0];
  assign cs_fall  = fall[0];
  assign sck_rise = rise[1];
  assign sck_fall = fall[1];

  spi_ee_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_s(lvl[0]), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(lvl[2]), .wp_s(lvl[3]), .busy(busy),
    .mem_rdata(rdata), .mem_raddr(raddr),
    .commit(mem_we), .commit_addr(waddr), .commit_data(wdata),
    .miso(miso), .miso_oe(miso_oe)
  );

  spi_ee_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  spi_ee_wrtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(mem_we), .busy(busy)
  );
endmodule

// File: rtl/spi_eeprom_checker.sv
module spi_eeprom_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic miso,
  input logic miso_oe,
  input logic busy,
  input logic wel,
  input logic cs_rise,
  input logic sck_fall,
  input logic mem_we
);
  // R1: two synchronised deselected samples leave the pad undriven
  p_oe_off_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_s) && $past(cs_s, 2)) |-> !miso_oe);

  // R2: driven data only moves right after a falling serial clock edge
  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(miso) && miso_oe && $past(miso_oe)) |-> $past(sck_fall));

  // R7: the pad is never driven while the write cycle runs
  p_no_read_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !busy);

  // R8: a write cycle starts only with the latch set and a store
  p_busy_needs_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel && mem_we));

  // R9: the latch clears only on deselect
  p_latch_clears_on_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(cs_rise));

  // R10: no store overlaps a running write cycle
  p_no_store_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);
endmodule

bind spi_eeprom_slave spi_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs_s(lvl[0]), .miso(miso), .miso_oe(miso_oe),
  .busy(busy), .wel(u_ctrl.wel_q), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .mem_we(mem_we)
);

// File: tb/tb_spi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_spi_eeprom_slave;
  localparam int H   = 8;
  localparam int WRC = 300;

  logic clk, rst_n, cs_n, sck, mosi, wp_n;
  logic miso, miso_oe, busy;
  int   n_chk = 0, n_fail = 0;
  int   quiet = 0;
  bit   reject_phase = 0;
  logic [7:0] ref_mem [int];

  spi_eeprom_slave #(.DEPTH(2048), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
    .miso(miso), .miso_oe(miso_oe), .busy(busy)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: pad must be quiet when deselected or rejected
  always @(negedge clk) begin
    if (rst_n) begin
      quiet = cs_n ? quiet + 1 : 0;
      if (quiet >= 4) chk(!miso_oe, "R1 oe while deselected", miso_oe, 0);
      if (reject_phase) chk(!miso_oe, "R7 oe during rejected read", miso_oe, 0);
    end
  end

  task automatic sel();
    cs_n = 0; repeat (H) @(negedge clk);
  endtask
  task automatic desel();
    repeat (H) @(negedge clk); cs_n = 1; repeat (4*H) @(negedge clk);
  endtask
  task automatic send(input logic [15:0] v, input int n);
    for (int i = n-1; i >= 0; i--) begin
      mosi = v[i];
      repeat (H) @(negedge clk); sck = 1;
      repeat (H) @(negedge clk); sck = 0;
    end
  endtask
  task automatic recv(output logic [7:0] b, output bit saw_oe, input int n);
    b = '0; saw_oe = 0;
    for (int i = 7; i > 7-n; i--) begin
      repeat (H) @(negedge clk);
      b[i] = miso; saw_oe |= miso_oe;
      if (!miso_oe) b[i] = 1'bx;
      sck = 1;
      repeat (H) @(negedge clk); sck = 0;
    end
  endtask
  task automatic cmd_only(input logic [7:0] op);
    sel(); send({8'h0, op}, 8); desel();
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  // write with nbits of data; model updates only when the rules allow
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int nbits, input bit model);
    sel(); send(16'h0002, 8); send(a, 16);
    send({d, 8'h0} >> (16 - nbits), nbits);
    desel();
    if (model) ref_mem[a & 16'h7FF] = d;
    wait_idle();
  endtask
  task automatic rd_check(input logic [15:0] a, input int nbytes, input string req);
    logic [7:0] b; bit s;
    int ea;
    sel(); send(16'h0003, 8); send(a, 16);
    ea = a & 16'h7FF;
    for (int k = 0; k < nbytes; k++) begin
      recv(b, s, 8);
      chk(b === ref_mem[ea], req, b, ref_mem[ea]);
      ea = (ea + 1) & 16'h7FF;
    end
    desel();
  endtask

  initial begin
    int blen;
    logic [7:0] b; bit s;
    cs_n = 1; sck = 0; mosi = 0; wp_n = 1; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!miso_oe && !busy, "R1 reset state", {miso_oe, busy}, 0);

    // preload via normal writes
    cmd_only(8'h06); wr(16'h07FF, 8'hA5, 8, 1);
    cmd_only(8'h06); wr(16'h0000, 8'h3C, 8, 1);
    cmd_only(8'h06); wr(16'h0001, 8'h5A, 8, 1);
    cmd_only(8'h06); wr(16'h0123, 8'h81, 8, 1);
    cmd_only(8'h06); wr(16'h0005, 8'hE7, 8, 1);

    rd_check(16'h0123, 1, "R2 single read");
    rd_check(16'h0000, 2, "R3 sequential read");
    rd_check(16'h07FF, 3, "R4 wrap to zero");
    rd_check(16'hF805, 1, "R5 upper address ignored");

    // R6: stop mid byte
    sel(); send(16'h0003, 8); send(16'h0000, 16); recv(b, s, 3);
    chk(s, "R6 oe during partial read", s, 1);
    repeat (H) @(negedge clk); cs_n = 1; repeat (6) @(negedge clk);
    chk(!miso_oe, "R6 oe after mid-byte deselect", miso_oe, 0);
    repeat (4*H) @(negedge clk);

    // R8: write without latch
    wr(16'h0123, 8'h00, 8, 0);
    rd_check(16'h0123, 1, "R8 write without latch ignored");

    // R9: short write aborts and clears latch
    cmd_only(8'h06); wr(16'h0123, 8'h11, 4, 0);
    rd_check(16'h0123, 1, "R9 short write discarded");
    wr(16'h0123, 8'h22, 8, 0);
    rd_check(16'h0123, 1, "R9 latch cleared by abort");
    cmd_only(8'h06); wr(16'h0123, 8'h33, 9, 0);
    rd_check(16'h0123, 1, "R9 nine-bit write discarded");

    // R11: write protect
    wp_n = 0; repeat (H) @(negedge clk);
    cmd_only(8'h06); wr(16'h0123, 8'h44, 8, 0);
    wp_n = 1; repeat (H) @(negedge clk);
    rd_check(16'h0123, 1, "R11 protected write discarded");
    wr(16'h0123, 8'h55, 8, 0);
    rd_check(16'h0123, 1, "R11 latch cleared by protected write");

    // R10 + R7: good write, busy length, rejected read
    cmd_only(8'h06);
    sel(); send(16'h0002, 8); send(16'h0123, 16); send(16'h0042, 8);
    repeat (H) @(negedge clk); cs_n = 1;
    ref_mem[16'h123] = 8'h42;
    blen = 0;
    for (int t = 0; t < 20 && !busy; t++) @(negedge clk);
    while (busy && blen < 10*WRC) begin blen++; @(negedge clk); end
    chk(blen == WRC, "R10 busy length", blen, WRC);
    // busy already ended; re-run a write to test reject window
    cmd_only(8'h06);
    sel(); send(16'h0002, 8); send(16'h0124, 16); send(16'h0099, 8);
    repeat (H) @(negedge clk); cs_n = 1;
    ref_mem[16'h124] = 8'h99;
    repeat (4*H) @(negedge clk);
    chk(busy, "R10 busy after store", busy, 1);
    reject_phase = 1;
    sel(); send(16'h0003, 8); send(16'h0123, 16); recv(b, s, 8);
    chk(!s, "R7 read refused while busy", s, 0);
    reject_phase = 0;
    desel(); wait_idle();
    rd_check(16'h0123, 2, "R10 stored data");
    wr(16'h0123, 8'h66, 8, 0);
    rd_check(16'h0123, 1, "R10 latch cleared after store");

    // R12: unknown opcode
    sel(); send(16'h0005, 8); send(16'h0000, 16); recv(b, s, 8);
    chk(!s, "R12 unknown opcode ignored", s, 0);
    desel();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule